// File: doc/BRIEF.md
# Variable-Width Serial Frame Engine

This block moves words between a parallel 16-bit data port and a four-wire serial link. The link uses the common clock-polarity/clock-phase serial format. A write places a word in a transmit queue. The shifter takes words from that queue one at a time and sends each one most significant bit first on the transmit line. At the same time it collects the same number of bits from the receive line, and the word it builds goes into a receive queue that the host drains through the read strobe. The frame length is chosen at run time from 4 to 16 bits. Narrow words are right-justified in both directions.

As a master, the engine makes the serial clock from an external bit-rate enable. It sends queued words back to back and holds its chip select low for the whole burst. As a slave, it follows an external clock and select. It can also release its transmit line so that several slaves can share one return wire. An internal loopback path joins the transmit shifter to the receive shifter, which lets the engine test itself. Turning the engine off stops the shifter. It does not empty either queue, so words can be loaded before a transfer is started.

Top module: `serial_frame_engine`

## Requirements
- R1: After reset the status outputs read: transmit empty 1, transmit not-full 1, receive not-empty 0, receive full 0, busy 0. Chip select is high and the master serial clock sits at the selected polarity.
- R2: The 4-bit size code sets the frame length. Code c from 3 to 15 gives c+1 bits. The reserved codes 0, 1 and 2 give 4 bits. Transmit bits above the frame length are ignored. A received word is right-justified with zeros above it.
- R3: Bits go out most significant first. When idle, the master clock rests at `cfg_cpol`. With `cfg_cpha`=0 data is captured on the first edge of each bit, and with `cfg_cpha`=1 on the second edge. The clock changes only on a `bit_tick` cycle, and each bit takes two ticks.
- R4: With `cfg_loop`=1 the receive shifter takes the transmit shifter's output. With `cfg_loop`=0 it takes `rxd_i`.
- R5: In slave role, `txd_oe` is 1 only while the engine is enabled, `cs_n_i` is low and `cfg_out_dis` is 0. In master role, `txd_oe` equals `cfg_enable`.
- R6: The role register loads `cfg_slave` (1 = slave) only in cycles where `cfg_enable` is 0. A change made while enabled has no effect until the engine is disabled.
- R7: While disabled, no transfer starts and both queues keep their contents. Words written before enabling are sent once the engine is enabled.
- R8: `st_busy` is 1 while a frame is in progress or the transmit queue holds a word.
- R9: Each queue holds 8 words. A write to a full transmit queue is dropped, and `st_tx_not_full` is 0 while the queue is full.
- R10: A frame that ends while the receive queue is full is discarded, and `overrun` pulses high for one cycle. The stored words are kept.
- R11: In master role, while the transmit queue holds data, frames follow one another with no gap and `cs_n_o` stays low through the whole burst.
- R12: In slave role, a frame runs while `cs_n_i` is low and is clocked by edges on `sclk_i`. The queued word is sent on `txd_o` and the bits on `rxd_i` are collected into the receive queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Port enable |
| cfg_slave | input | 1 | Role request: 1 = slave, 0 = master |
| cfg_cpol | input | 1 | Idle level of the serial clock |
| cfg_cpha | input | 1 | 0 = capture on first edge, 1 = capture on second edge |
| cfg_loop | input | 1 | Internal loopback |
| cfg_out_dis | input | 1 | Slave transmit-line release |
| cfg_size | input | 4 | Frame size code |
| bit_tick | input | 1 | Master half-bit rate enable |
| wr_en | input | 1 | Transmit queue write strobe |
| wr_data | input | 16 | Right-justified transmit word |
| rd_en | input | 1 | Receive queue pop strobe |
| rd_data | output | 16 | Head of the receive queue |
| st_busy | output | 1 | Frame in progress or transmit data pending |
| st_tx_empty | output | 1 | Transmit queue empty |
| st_tx_not_full | output | 1 | Transmit queue has space |
| st_rx_not_empty | output | 1 | Receive queue holds data |
| st_rx_full | output | 1 | Receive queue full |
| overrun | output | 1 | One-cycle pulse when a received frame is lost |
| sclk_o | output | 1 | Master serial clock |
| cs_n_o | output | 1 | Master chip select, active low |
| sclk_i | input | 1 | Slave serial clock |
| cs_n_i | input | 1 | Slave select, active low |
| txd_o | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Transmit line drive enable |
| rxd_i | input | 1 | Serial receive data |

## Verification
Two pairs of events can land in the same clock edge. The first is the end of a frame, which pushes into the receive queue, and a host read, which pops it. The second is the start of the next back-to-back frame, which pops the transmit queue, and a host write, which pushes it. The bench's monitor reads the receive queue the moment it becomes non-empty during bursts, so the push-while-pop case happens naturally. The bench judges it by comparing every read word in order against a scoreboard queue. The overrun case is forced on purpose: the receive queue is filled while no reads are made, one more frame is sent, and the bench then checks for exactly one overrun pulse and for the eight original words coming back unchanged and in order.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam int SFE_DW = 16;
  localparam int SFE_NW = 5;   // holds a bit count 0..16
  localparam int SFE_EW = 6;   // holds an edge count 0..31

  // size code to frame length; reserved low codes fall back to 4 bits
  function automatic logic [SFE_NW-1:0] frame_bits(input logic [3:0] code);
    if (code < 4'd3) frame_bits = SFE_NW'(4);
    else             frame_bits = {1'b0, code} + SFE_NW'(1);
  endfunction

  // move a right-justified word so its top used bit sits at bit 15
  function automatic logic [SFE_DW-1:0] align_msb(input logic [SFE_DW-1:0] w,
                                                  input logic [SFE_NW-1:0] n);
    align_msb = w << (SFE_NW'(SFE_DW) - n);
  endfunction

  // last edge index of a frame of n bits (two edges per bit)
  function automatic logic [SFE_EW-1:0] last_edge_idx(input logic [SFE_NW-1:0] n);
    last_edge_idx = {n, 1'b0} - SFE_EW'(1);
  endfunction
endpackage

// File: rtl/sfe_fifo.sv
module sfe_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    ptr_next = (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  // R9
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> ($stable(count) && $stable(wr_ptr)));
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter
  import sfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              master,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              loop,
  input  logic [3:0]        size_code,
  input  logic              bit_tick,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  input  logic              rxd_i,
  input  logic              tx_empty,
  input  logic [SFE_DW-1:0] tx_word,
  input  logic              rx_full,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [SFE_DW-1:0] rx_word,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              txd_o,
  output logic              active_o,
  output logic              overrun_o
);
  logic              sclk_q, sclk_prev, cs_q;
  logic              active, active_d;
  logic [SFE_EW-1:0] edge_cnt;
  logic [SFE_NW-1:0] nbits;
  logic [SFE_DW-1:0] tx_sr, rx_sr, rx_next;
  logic              sclk_r, cs_r, ovr_r;

  // named internal events
  logic edge_evt, lead, sample_evt, shift_evt, frame_done, want, start, abort, rx_in;

  assign edge_evt   = active && (master ? bit_tick : (sclk_q != sclk_prev));
  assign lead       = ~edge_cnt[0];
  assign sample_evt = edge_evt && (lead ^ cpha);
  assign shift_evt  = edge_evt && (cpha ? (lead && edge_cnt != '0) : !lead);
  assign frame_done = edge_evt && (edge_cnt == last_edge_idx(nbits));
  assign want       = enable && (master ? !tx_empty : !cs_q);
  assign start      = want && (!active || frame_done);
  assign abort      = !enable || (!master && cs_q);
  assign rx_in      = loop ? tx_sr[SFE_DW-1] : rxd_i;
  assign rx_next    = sample_evt ? {rx_sr[SFE_DW-2:0], rx_in} : rx_sr;

  always_comb begin
    active_d = active;
    if (frame_done) active_d = 1'b0;
    if (start)      active_d = 1'b1;
    if (abort)      active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      sclk_prev <= 1'b0;
      cs_q      <= 1'b1;
      active    <= 1'b0;
      edge_cnt  <= '0;
      nbits     <= SFE_NW'(4);
      tx_sr     <= '0;
      rx_sr     <= '0;
      sclk_r    <= 1'b0;
      cs_r      <= 1'b1;
      ovr_r     <= 1'b0;
    end else begin
      sclk_q    <= sclk_i;
      sclk_prev <= sclk_q;
      cs_q      <= cs_n_i;
      active    <= active_d;
      ovr_r     <= frame_done && rx_full;
      cs_r      <= !(active_d && master);
      if (!active_d || !master) sclk_r <= cpol;
      else if (edge_evt)        sclk_r <= ~sclk_r;
      if (start) begin
        edge_cnt <= '0;
        nbits    <= frame_bits(size_code);
        tx_sr    <= align_msb(tx_empty ? '0 : tx_word, frame_bits(size_code));
        rx_sr    <= '0;
      end else if (edge_evt) begin
        edge_cnt <= edge_cnt + SFE_EW'(1);
        rx_sr    <= rx_next;
        if (shift_evt) tx_sr <= tx_sr << 1;
      end
    end
  end

  assign tx_pop    = start && !tx_empty;
  assign rx_push   = frame_done && !rx_full;
  assign rx_word   = rx_next;
  assign sclk_o    = sclk_r;
  assign cs_n_o    = cs_r;
  assign txd_o     = tx_sr[SFE_DW-1];
  assign active_o  = active;
  assign overrun_o = ovr_r;

  // R11
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && enable && frame_done && !tx_empty) |=> (active && !cs_n_o));

  // R2
  edge_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (edge_cnt <= last_edge_idx(nbits)));

  // R3
  sclk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && enable && active && !bit_tick) |=> $stable(sclk_o));
endmodule

// File: rtl/serial_frame_engine.sv
module serial_frame_engine
  import sfe_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_slave,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_loop,
  input  logic              cfg_out_dis,
  input  logic [3:0]        cfg_size,
  input  logic              bit_tick,
  input  logic              wr_en,
  input  logic [SFE_DW-1:0] wr_data,
  input  logic              rd_en,
  output logic [SFE_DW-1:0] rd_data,
  output logic              st_busy,
  output logic              st_tx_empty,
  output logic              st_tx_not_full,
  output logic              st_rx_not_empty,
  output logic              st_rx_full,
  output logic              overrun,
  output logic              sclk_o,
  output logic              cs_n_o,
  input  logic              sclk_i,
  input  logic              cs_n_i,
  output logic              txd_o,
  output logic              txd_oe,
  input  logic              rxd_i
);
  logic              slave_q;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_pop, rx_push, active;
  logic [SFE_DW-1:0] tx_head, rx_word;

  // role may only follow the request while the port is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           slave_q <= 1'b0;
    else if (!cfg_enable) slave_q <= cfg_slave;
  end

  sfe_fifo #(.W(SFE_DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .pop(tx_pop), .wdata(wr_data),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty));

  sfe_fifo #(.W(SFE_DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .pop(rd_en), .wdata(rx_word),
    .rdata(rd_data), .full(rx_full), .empty(rx_empty));

  sfe_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .master(!slave_q),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .loop(cfg_loop), .size_code(cfg_size),
    .bit_tick(bit_tick), .sclk_i(sclk_i), .cs_n_i(cs_n_i), .rxd_i(rxd_i),
    .tx_empty(tx_empty), .tx_word(tx_head), .rx_full(rx_full),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .txd_o(txd_o), .active_o(active),
    .overrun_o(overrun));

  assign st_busy         = active || !tx_empty;
  assign st_tx_empty     = tx_empty;
  assign st_tx_not_full  = !tx_full;
  assign st_rx_not_empty = !rx_empty;
  assign st_rx_full      = rx_full;
  assign txd_oe          = cfg_enable && (!slave_q || (!cs_n_i && !cfg_out_dis));

  // R6
  role_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_enable) |-> $stable(slave_q));

  // R10
  overrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);
endmodule

// File: tb/serial_frame_engine_test.sv
module serial_frame_engine_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_enable = 0, cfg_slave = 0, cfg_cpol = 0, cfg_cpha = 0, cfg_loop = 1, cfg_out_dis = 0;
  logic [3:0] cfg_size = 4'd7;
  logic bit_tick = 1'b1;
  logic wr_en = 0, rd_en = 0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic st_busy, st_tx_empty, st_tx_not_full, st_rx_not_empty, st_rx_full, overrun;
  logic sclk_o, cs_n_o, txd_o, txd_oe, rxd_i;
  logic sclk_i = 0, cs_n_i = 1, rxd_drv = 0;
  logic slv_mode = 0;

  int checks = 0, errors = 0;
  int tick_div = 1;
  int cur_n = 8;
  logic [15:0] cur_mask = 16'h00FF;
  bit mon_on = 1;
  bit finished = 0;
  int cs_rises = 0, ovr_count = 0;
  logic [15:0] exp_rx[$];
  logic [15:0] exp_tx[$];

  always #10 clk = ~clk;  // 50 MHz

  assign rxd_i = slv_mode ? rxd_drv : ~txd_o;

  serial_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_slave(cfg_slave),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_loop(cfg_loop),
    .cfg_out_dis(cfg_out_dis), .cfg_size(cfg_size), .bit_tick(bit_tick),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .st_busy(st_busy), .st_tx_empty(st_tx_empty), .st_tx_not_full(st_tx_not_full),
    .st_rx_not_empty(st_rx_not_empty), .st_rx_full(st_rx_full), .overrun(overrun),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .sclk_i(sclk_i), .cs_n_i(cs_n_i),
    .txd_o(txd_o), .txd_oe(txd_oe), .rxd_i(rxd_i));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bench's own view of the size code
  function automatic int bits_of(input logic [3:0] c);
    return (c <= 4'd2) ? 4 : int'(c) + 1;
  endfunction

  // rate enable generator
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (tick_div <= 1) bit_tick = 1'b1;
      else begin
        bit_tick = (cnt == 0);
        cnt = (cnt + 1) % tick_div;
      end
    end
  end

  // monitor: receive scoreboard, wire capture, event counters
  initial begin
    logic sclk_p = 0, txd_p = 0, cs_p = 1;
    logic [15:0] cap = '0;
    int capn = 0;
    forever begin
      @(negedge clk);
      if (rd_en) rd_en = 1'b0;
      else if (mon_on && st_rx_not_empty) begin
        if (exp_rx.size() == 0)
          chk(0, "R9", "unexpected receive word", rd_data, 0);
        else begin
          logic [15:0] e;
          e = exp_rx.pop_front();
          chk(rd_data == e, "R4", "received word", rd_data, e);
        end
        rd_en = 1'b1;
      end
      if (!slv_mode && !cs_p && sclk_o != sclk_p) begin
        if ((sclk_o != cfg_cpol) ^ cfg_cpha) begin
          cap = {cap[14:0], txd_p};
          capn++;
          if (capn == cur_n) begin
            logic [15:0] e;
            e = (exp_tx.size() != 0) ? exp_tx.pop_front() : 16'hDEAD;
            chk((cap & cur_mask) == e, "R3", "wire word", cap & cur_mask, e);
            capn = 0;
            cap = '0;
          end
        end
      end
      if (cs_n_o) capn = 0;
      if (cs_n_o && !cs_p) cs_rises++;
      if (overrun) ovr_count++;
      sclk_p = sclk_o;
      txd_p = txd_o;
      cs_p = cs_n_o;
    end
  end

  task automatic set_cfg(input logic en, input logic pol, input logic pha,
                         input logic [3:0] code, input logic lp);
    @(negedge clk);
    cfg_enable = 0;
    @(negedge clk);
    cfg_cpol = pol; cfg_cpha = pha; cfg_size = code; cfg_loop = lp;
    cur_n = bits_of(code);
    cur_mask = 16'((32'h1 << cur_n) - 1);
    @(negedge clk);
    cfg_enable = en;
  endtask

  task automatic send_raw(input logic [15:0] w);
    @(negedge clk);
    wr_en = 1; wr_data = w;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic send(input logic [15:0] w, input bit exp_in_rx);
    exp_tx.push_back(w & cur_mask);
    if (exp_in_rx) exp_rx.push_back(cfg_loop ? (w & cur_mask) : (~w & cur_mask));
    send_raw(w);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (st_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_drain();
    wait_idle();
    repeat (40) @(negedge clk);
  endtask

  task automatic slave_xfer(input logic [7:0] rx, output logic [7:0] got, output logic oe_seen);
    got = '0;
    @(negedge clk);
    cs_n_i = 0;
    repeat (4) @(negedge clk);
    oe_seen = txd_oe;
    for (int i = 7; i >= 0; i--) begin
      rxd_drv = rx[i];
      repeat (4) @(negedge clk);
      got = {got[6:0], txd_o};
      sclk_i = 1;
      repeat (4) @(negedge clk);
      sclk_i = 0;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    cs_n_i = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R8 watchdog: actual hung expected idle");
    finish_run();
  end

  initial begin
    int r0;
    logic [7:0] got;
    logic oe;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(st_tx_empty == 1, "R1", "tx empty", st_tx_empty, 1);
    chk(st_tx_not_full == 1, "R1", "tx not full", st_tx_not_full, 1);
    chk(st_rx_not_empty == 0, "R1", "rx not empty", st_rx_not_empty, 0);
    chk(st_rx_full == 0, "R1", "rx full", st_rx_full, 0);
    chk(st_busy == 0, "R1", "busy", st_busy, 0);
    chk(cs_n_o == 1 && sclk_o == 0, "R1", "cs/sclk idle", {cs_n_o, sclk_o}, 2'b10);

    // R2 upper bits ignored, loopback 8-bit frames
    set_cfg(1, 0, 0, 4'd7, 1);
    send(16'h01A5, 1);
    send(16'hFF3C, 1);
    wait_drain();

    // R3 R4 R11 mode sweep, external inverted return path
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 3; s++) begin
        logic [3:0] code;
        code = (s == 0) ? 4'd3 : (s == 1) ? 4'd11 : 4'd15;
        tick_div = (s == 1) ? 3 : 1;
        set_cfg(1, m[1], m[0], code, 0);
        r0 = cs_rises;
        send(16'hB4C9 ^ 16'(m * 16'h1111), 1);
        send(16'h6D21 + 16'(s), 1);
        send(16'h8001, 1);
        wait_drain();
        // R11 a single chip-select window for the burst
        chk(cs_rises - r0 == 1, "R11", "cs windows per burst", cs_rises - r0, 1);
        // R3 idle clock level
        chk(sclk_o == m[1], "R3", "idle sclk level", sclk_o, m[1]);
      end
    end
    tick_div = 1;

    // R2 reserved code acts as 4 bits
    set_cfg(1, 0, 0, 4'd1, 1);
    send(16'hFFFF, 1);
    wait_drain();
    chk(exp_rx.size() == 0, "R2", "reserved code words left", exp_rx.size(), 0);

    // R7 R8 preload while disabled
    set_cfg(0, 0, 1, 4'd9, 1);
    r0 = cs_rises;
    send(16'h0123, 1);
    send(16'h0345, 1);
    send(16'h03FF, 1);
    repeat (10) @(negedge clk);
    chk(st_busy == 1, "R8", "busy with queued data", st_busy, 1);
    chk(st_tx_empty == 0 && cs_n_o == 1, "R7", "held while disabled", {st_tx_empty, cs_n_o}, 2'b01);
    chk(cs_rises == r0, "R7", "no transfer while disabled", cs_rises - r0, 0);
    cfg_enable = 1;
    wait_drain();
    chk(st_busy == 0, "R8", "busy after drain", st_busy, 0);
    chk(exp_rx.size() == 0 && exp_tx.size() == 0, "R7", "preloaded words sent", exp_rx.size(), 0);

    // R7 receive queue kept across disable
    mon_on = 0;
    send(16'h0111, 1);
    send(16'h0222, 1);
    wait_idle();
    cfg_enable = 0;
    repeat (10) @(negedge clk);
    chk(st_rx_not_empty == 1, "R7", "rx kept while disabled", st_rx_not_empty, 1);
    mon_on = 1;
    repeat (20) @(negedge clk);
    chk(exp_rx.size() == 0, "R7", "kept words read", exp_rx.size(), 0);

    // R9 R10 full transmit queue and receive overrun
    set_cfg(0, 1, 0, 4'd7, 1);
    mon_on = 0;
    for (int i = 0; i < 8; i++) send(16'h0010 + 16'(i * 7), 1);
    chk(st_tx_not_full == 0, "R9", "tx full flag", st_tx_not_full, 0);
    send_raw(16'h00EE);
    chk(st_tx_not_full == 0, "R9", "still full after drop", st_tx_not_full, 0);
    r0 = ovr_count;
    cfg_enable = 1;
    wait_idle();
    chk(st_rx_full == 1, "R10", "rx full", st_rx_full, 1);
    chk(ovr_count == r0, "R10", "no overrun yet", ovr_count - r0, 0);
    send(16'h0077, 0);
    wait_idle();
    chk(ovr_count - r0 == 1, "R10", "overrun pulses", ovr_count - r0, 1);
    chk(st_rx_full == 1, "R10", "rx still full", st_rx_full, 1);
    mon_on = 1;
    repeat (40) @(negedge clk);
    chk(exp_rx.size() == 0 && st_rx_not_empty == 0, "R9", "exactly eight stored", exp_rx.size(), 0);

    // R6 role change while enabled is ignored
    set_cfg(1, 0, 0, 4'd7, 1);
    @(negedge clk);
    cfg_slave = 1;
    r0 = cs_rises;
    send(16'h0042, 1);
    wait_drain();
    chk(cs_rises - r0 == 1, "R6", "still master", cs_rises - r0, 1);
    chk(txd_oe == 1, "R5", "master drives line", txd_oe, 1);

    // R12 R5 slave transfer
    slv_mode = 1;
    set_cfg(0, 0, 0, 4'd7, 0);
    repeat (2) @(negedge clk);
    send_raw(16'h005A);
    exp_rx.push_back(16'h00C3);
    cfg_enable = 1;
    repeat (3) @(negedge clk);
    chk(txd_oe == 0, "R5", "slave unselected oe", txd_oe, 0);
    r0 = cs_rises;
    slave_xfer(8'hC3, got, oe);
    chk(got == 8'h5A, "R12", "slave sent word", got, 8'h5A);
    chk(oe == 1, "R5", "slave selected oe", oe, 1);
    chk(cs_rises == r0 && cs_n_o == 1, "R6", "slave role after disable", cs_rises - r0, 0);
    repeat (20) @(negedge clk);
    chk(exp_rx.size() == 0, "R12", "slave received word", exp_rx.size(), 0);
    cfg_out_dis = 1;
    @(negedge clk);
    cs_n_i = 0;
    repeat (3) @(negedge clk);
    chk(txd_oe == 0, "R5", "output disabled oe", txd_oe, 0);
    cs_n_i = 1;
    repeat (10) @(negedge clk);
    chk(st_rx_not_empty == 0, "R12", "aborted frame not stored", st_rx_not_empty, 0);
    finish_run();
  end
endmodule